// File: doc/BRIEF.md
# Unaligned 16-byte load extractor

This block serves 128-bit loads from any byte address, using a memory port that only delivers whole 16-byte lines from 16-byte-aligned addresses. A requester offers a byte address on a valid/ready handshake. When the four low address bits are zero, the block reads a single line and returns it as it is. When they are not zero, the block reads two consecutive aligned lines. The first line starts at the request address with its low four bits cleared. Together the two lines form a 32-byte window, and the block picks out the 16 bytes that start at the requested byte.

The memory port has a fixed one-cycle latency. Data for a read issued in one cycle appear on the read-data bus in the next cycle. The bus is little-endian, and within the window the line with the lower address occupies the low half. Only one request is in flight at a time. The block stays not-ready from acceptance until its one-cycle response pulse has been issued.

Top module: `ulx_load_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, req_ready is 1 and both rsp_valid and mem_rd_en are 0.
- R2: req_ready is 1 only when the block is idle. It goes to 0 in the cycle after a request is accepted (req_valid and req_ready both 1 at a clock edge), stays 0 through the response cycle, and returns to 1 in the cycle after it.
- R3: In the cycle after acceptance, the block issues exactly one read, at the request address with bits [3:0] cleared.
- R4: For an unaligned request (address bits [3:0] not zero), a second read follows in the next cycle, at the first read address plus 16. An aligned request issues no second read.
- R5: rsp_valid is a single-cycle pulse. It comes 2 cycles after acceptance for an aligned request and 3 cycles after acceptance for an unaligned one.
- R6: For an unaligned request with offset k = address[3:0], response byte i (bits 8i+7..8i) equals window byte k+i. Window bytes 0..15 are the lower line and bytes 16..31 are the upper line. The response therefore equals the 16 memory bytes starting at the request address.
- R7: For an aligned request, the response equals the single line read, unchanged.
- R8: req_valid and req_addr have no effect while req_ready is 0. No extra read is issued, and the response reflects only the accepted address.
- R9: The upper-line address wraps modulo 2^ADDR_W. A request in the last line of the address space reads the upper half of its window from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Byte address of the 16-byte load |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Line-aligned read address |
| mem_rd_data | input | 8*LINE_BYTES | Line data, valid the cycle after mem_rd_en |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 8*LINE_BYTES | Extracted 16 bytes, little-endian; zero when not valid |

## Verification
Two things can happen in the same cycle. The upper-line read of an unaligned request goes out while the lower-line data sits on the bus and is being captured. A new req_valid can also arrive in the very cycle the response pulse is issued. The bench provokes both: it keeps req_valid high with changing addresses throughout busy periods, and it returns random data on cycles with no read. A behavioural model predicts ready, read strobe, read address, response pulse and data for every cycle. Any mix-up between the capture and the second read, or any early acceptance, shows up as a per-cycle mismatch against bytes computed directly from the request address.

// File: rtl/ulx_pkg.sv
package ulx_pkg;

    localparam int ULX_ADDR_W_DEF     = 32;
    localparam int ULX_LINE_BYTES_DEF = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DONE = 2'd3
    } ulx_state_e;

    typedef struct packed {
        logic cap_lo;
        logic split;
        logic rsp;
    } ulx_ctl_t;

    function automatic logic is_reading(ulx_state_e s);
        return (s == ST_LO) || (s == ST_HI);
    endfunction

endpackage

// File: rtl/ulx_ctrl.sv
module ulx_ctrl
    import ulx_pkg::*;
#(
    parameter int ADDR_W     = ULX_ADDR_W_DEF,
    parameter int LINE_BYTES = ULX_LINE_BYTES_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        req_ready,
    output logic                        mem_rd_en,
    output logic [ADDR_W-1:0]           mem_rd_addr,
    output ulx_ctl_t                    ctl,
    output logic [$clog2(LINE_BYTES)-1:0] ofs
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    ulx_state_e              state_q, state_d;
    logic [ADDR_W-1:0]       base_q;
    logic [OFS_W-1:0]        ofs_q;
    logic                    accept;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign req_ready = (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_LO;
            ST_LO:   state_d = (ofs_q == '0) ? ST_DONE : ST_HI;
            ST_HI:   state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            ofs_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                base_q <= {req_addr[ADDR_W-1:OFS_W], OFS_W'(0)};
                ofs_q  <= req_addr[OFS_W-1:0];
            end
        end
    end

    assign mem_rd_en   = is_reading(state_q);
    assign mem_rd_addr = (state_q == ST_HI) ? (base_q + ADDR_W'(LINE_BYTES)) : base_q;

    assign ctl.cap_lo = (state_q == ST_HI);
    assign ctl.split  = (ofs_q != '0);
    assign ctl.rsp    = (state_q == ST_DONE);
    assign ofs        = ofs_q;

    // R4, R9: back-to-back reads step exactly one line, wrapping
    p_hi_line_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(LINE_BYTES)));

    // R8: no memory traffic while idle
    p_idle_no_read_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_rd_en);

endmodule

// File: rtl/ulx_window.sv
module ulx_window
    import ulx_pkg::*;
#(
    parameter int LINE_BYTES = ULX_LINE_BYTES_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  ulx_ctl_t                    ctl,
    input  logic [8*LINE_BYTES-1:0]     mem_rd_data,
    output logic [16*LINE_BYTES-1:0]    window
);
    localparam int DATA_W = 8 * LINE_BYTES;

    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (ctl.cap_lo) begin
            lo_q <= mem_rd_data;
        end
    end

    assign window = ctl.split ? {mem_rd_data, lo_q} : {mem_rd_data, mem_rd_data};

    // R6: the lower half of a split window is the line captured in the read-high cycle
    p_lo_held_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.rsp && ctl.split) |-> (window[DATA_W-1:0] == $past(mem_rd_data)));

endmodule

// File: rtl/ulx_shifter.sv
module ulx_shifter
    import ulx_pkg::*;
#(
    parameter int LINE_BYTES = ULX_LINE_BYTES_DEF
) (
    input  logic [16*LINE_BYTES-1:0]       window,
    input  logic [$clog2(LINE_BYTES)-1:0]  ofs,
    output logic [8*LINE_BYTES-1:0]        dout
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int IDX_W = OFS_W + 1;

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
        logic [IDX_W-1:0] idx;
        assign idx = {1'b0, ofs} + IDX_W'(i);
        assign dout[i*8 +: 8] = window[idx*8 +: 8];
    end

endmodule

// File: rtl/ulx_load_unit.sv
module ulx_load_unit
    import ulx_pkg::*;
#(
    parameter int ADDR_W     = ULX_ADDR_W_DEF,
    parameter int LINE_BYTES = ULX_LINE_BYTES_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      mem_rd_en,
    output logic [ADDR_W-1:0]         mem_rd_addr,
    input  logic [8*LINE_BYTES-1:0]   mem_rd_data,
    output logic                      rsp_valid,
    output logic [8*LINE_BYTES-1:0]   rsp_data
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int DATA_W = 8 * LINE_BYTES;
    localparam int WIN_W  = 2 * DATA_W;

    ulx_ctl_t           ctl;
    logic [OFS_W-1:0]   ofs;
    logic [WIN_W-1:0]   window;
    logic [DATA_W-1:0]  extracted;

    ulx_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .ctl(ctl), .ofs(ofs)
    );

    ulx_window #(.LINE_BYTES(LINE_BYTES)) u_window (
        .clk(clk), .rst(rst), .ctl(ctl),
        .mem_rd_data(mem_rd_data), .window(window)
    );

    ulx_shifter #(.LINE_BYTES(LINE_BYTES)) u_shift (
        .window(window), .ofs(ofs), .dout(extracted)
    );

    assign rsp_valid = ctl.rsp;
    assign rsp_data  = ctl.rsp ? extracted : '0;

    logic accept, acc_al, acc_un;
    assign accept = req_valid && req_ready;
    assign acc_al = accept && (req_addr[OFS_W-1:0] == '0);
    assign acc_un = accept && (req_addr[OFS_W-1:0] != '0);

    // R1: reset leaves the unit idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_rd_en));

    // R2: busy from acceptance through the response
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);
    p_no_ready_on_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);
    p_ready_after_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    // R3: first read right after acceptance, line aligned
    p_read_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mem_rd_en && (mem_rd_addr[OFS_W-1:0] == '0)));

    // R5: single pulse, latency set by alignment
    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(acc_al, 2) || $past(acc_un, 3)));

    // R7: aligned response is the line on the bus
    p_aligned_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (ofs == '0)) |-> (rsp_data == mem_rd_data));

endmodule

// File: tb/ulx_load_unit_test.sv
`timescale 1ns/1ps
module ulx_load_unit_test;

    localparam int ADDR_W = 32;
    localparam int LB     = 16;
    localparam int DW     = 8 * LB;
    localparam int NREQ   = 400;
    localparam int NDIR   = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DW-1:0]     mem_rd_data;
    logic              rsp_valid;
    logic [DW-1:0]     rsp_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ulx_load_unit #(.ADDR_W(ADDR_W), .LINE_BYTES(LB)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [7:0] mem_byte(logic [ADDR_W-1:0] a);
        logic [31:0] h;
        h = a * 32'h9E3779B1;
        return h[31:24] ^ a[7:0];
    endfunction

    function automatic logic [DW-1:0] bytes_from(logic [ADDR_W-1:0] a);
        logic [DW-1:0] v;
        for (int i = 0; i < LB; i++) v[i*8 +: 8] = mem_byte(a + ADDR_W'(i));
        return v;
    endfunction

    // memory with one-cycle latency; garbage on idle cycles
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= bytes_from(mem_rd_addr);
        else           mem_rd_data <= {$urandom, $urandom, $urandom, $urandom};
    end

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [ADDR_W-1:0] dir_addr(int k);
        case (k)
            0: return 32'h0000_0100;
            1: return 32'h0000_0101;
            2: return 32'h0000_010F;
            3: return 32'h0000_0108;
            4: return 32'h0000_0200;
            5: return 32'hFFFF_FFF9;
            6: return 32'hFFFF_FFF0;
            7: return 32'h0000_0003;
            8: return 32'h0000_07F0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // reference model state
    bit                m_busy = 1'b0;
    int                m_p    = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    int                sent   = 0;

    task automatic compare_cycle();
        bit al;
        int last;
        logic [ADDR_W-1:0] base;
        bit exp_rd, exp_rsp;
        al   = (m_addr[3:0] == 4'h0);
        last = al ? 2 : 3;
        base = {m_addr[ADDR_W-1:4], 4'h0};
        exp_rd  = m_busy && ((m_p == 1) || (m_p == 2 && !al));
        exp_rsp = m_busy && (m_p == last);
        chk("R2 req_ready", DW'(req_ready), DW'(!m_busy));
        chk(al ? "R3 mem_rd_en" : "R4 mem_rd_en", DW'(mem_rd_en), DW'(exp_rd));
        chk("R8 stray read", DW'(mem_rd_en && !m_busy), DW'(0));
        if (exp_rd && m_p == 1) chk("R3 first read addr", DW'(mem_rd_addr), DW'(base));
        if (exp_rd && m_p == 2) begin
            if (base == {{(ADDR_W-4){1'b1}}, 4'h0})
                chk("R9 wrapped upper addr", DW'(mem_rd_addr), DW'(0));
            else
                chk("R4 upper addr", DW'(mem_rd_addr), DW'(base + 32'd16));
        end
        chk("R5 rsp_valid", DW'(rsp_valid), DW'(exp_rsp));
        if (exp_rsp) begin
            if (al) chk("R7 aligned data", rsp_data, bytes_from(m_addr));
            else    chk("R6 extracted data", rsp_data, bytes_from(m_addr));
        end
    endtask

    task automatic model_step();
        if (!m_busy && req_valid) begin
            m_busy = 1'b1;
            m_p    = 1;
            m_addr = req_addr;
            sent++;
        end else if (m_busy) begin
            if (m_p == ((m_addr[3:0] == 4'h0) ? 2 : 3)) m_busy = 1'b0;
            else m_p++;
        end
    endtask

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_addr  = '0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 ready in reset", DW'(req_ready), DW'(1));
            chk("R1 no rsp in reset", DW'(rsp_valid), DW'(0));
            chk("R1 no read in reset", DW'(mem_rd_en), DW'(0));
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", DW'({req_ready, rsp_valid, mem_rd_en}), DW'(3'b100));
        for (int cyc = 0; cyc < 20000 && (sent < NREQ || m_busy); cyc++) begin
            compare_cycle();
            if (sent >= NREQ) begin
                req_valid = 1'b0;
            end else if (!m_busy) begin
                req_valid = ($urandom_range(3, 0) != 0);
                req_addr  = (sent < NDIR) ? dir_addr(sent) : $urandom;
            end else begin
                // R8: noise while busy must be ignored
                req_valid = ($urandom_range(1, 0) != 0);
                req_addr  = $urandom;
            end
            model_step();
            @(negedge clk);
        end
        compare_cycle();
        chk("R5 all requests served", DW'(sent), DW'(NREQ));
        finish_run();
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

endmodule